// File: doc/BRIEF.md
# Flash Sector Protection Sequencer

This block changes the write protection of one sector in a parallel NOR flash and then confirms that the change took effect. The caller gives it a sector base address and a lock or unlock choice, then pulses `start`. The block issues the protection command three times. The lock or unlock choice is carried on a single address line, not in the data. The block then puts the device into identification mode and reads the sector's protection status word. Finally it returns the device to read mode with a reset command.

When the sequence ends, the block reports pass or fail with a one-cycle `done` pulse. A request that covers several sectors is handled by the caller, which starts the block once per sector.

The bus is a simple synchronous one. Each cycle carries at most one transfer: a write strobe with address and data, or a read strobe with address. Read data must be valid in the same cycle as the read strobe. The block samples it at the clock edge that ends that cycle. All addresses are byte addresses. Command word offsets are multiplied by `BUS_BYTES`, and all address arithmetic wraps modulo 2^`ADDR_W`.

Top module: `fprot_seq`

## Requirements
- R1: When the block is idle, a `start` pulse latches `sect_base` and `unlock` and raises `busy` on the next cycle. `busy` then stays high for exactly 10 cycles, one bus transfer per cycle. A `start` that arrives while `busy` is high is ignored and does not launch a second sequence.
- R2: The first transfer of every sequence writes 0xF0 to address 0.
- R3: Transfers 2 to 4 each write 0x60 to the protection address. That address is the sector base with byte-address bit (6 + log2 `BUS_BYTES`) set to 1 for unlock and cleared to 0 for lock. All other bits of the base are kept.
- R4: Transfers 5 to 8 are, in order:
  - 0xF0 written to address 0;
  - 0xAA written to base + 0x555·`BUS_BYTES`;
  - 0x55 written to base + 0x2AA·`BUS_BYTES`;
  - 0x90 written to base + 0x555·`BUS_BYTES`.
- R5: Transfer 9 is a read of base + 2·`BUS_BYTES`. The status word is taken from `fl_rdata` during that cycle.
- R6: Transfer 10, the last one, writes 0xF0 to address 0.
- R7: In the cycle after the last transfer, `busy` is low and `done` is high for exactly one cycle. With it, `err` is 1 in two cases: an unlock request whose status word is nonzero (locked), or a lock request whose status word is zero (unlocked). Otherwise `err` is 0.
- R8: `fl_we` and `fl_re` are never high together, and neither is high while `busy` is low. `err` is low whenever `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a protection change (accepted only when idle) |
| sect_base | input | ADDR_W | Byte base address of the target sector |
| unlock | input | 1 | 1 = unlock the sector, 0 = lock it |
| busy | output | 1 | High for the whole sequence |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Verification failed; valid with `done` |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | DATA_W | Flash write data |
| fl_rdata | input | DATA_W | Flash read data, valid in the read strobe cycle |

## Verification
The bench runs every combination of four sector bases, both directions, both prior protection states, and a flash model that either obeys or ignores the protection command. It checks each of the ten transfers against its own address arithmetic.

Three mistakes are targeted directly:
- A design that forces the wrong address line, or clears the line during an unlock, would move the 0x60 writes to the wrong address. The chosen bases already have that line set or cleared to expose this.
- A design that inverts the pass/fail decision, or tests the status word against the wrong direction, would flag failures on the stuck-model cases the wrong way.
- A design that accepted a second `start` in mid-sequence would corrupt the transfer log or extend `busy` beyond ten cycles.

// File: rtl/fprot_pkg.sv
package fprot_pkg;
  localparam int unsigned STEPS     = 10;
  localparam int unsigned STEP_W    = 4;
  localparam int unsigned RD_STEP   = 8;
  localparam int unsigned LAST_STEP = STEPS - 1;

  localparam logic [7:0] CMD_RESET = 8'hF0;
  localparam logic [7:0] CMD_PROT  = 8'h60;
  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_IDENT = 8'h90;

  localparam logic [11:0] WOFS_KEY1   = 12'h555;
  localparam logic [11:0] WOFS_KEY2   = 12'h2AA;
  localparam logic [11:0] WOFS_STATUS = 12'h002;

  typedef enum logic [1:0] {
    XF_NONE  = 2'd0,
    XF_WRITE = 2'd1,
    XF_READ  = 2'd2
  } xfer_kind_e;
endpackage

// File: rtl/fprot_step_rom.sv
module fprot_step_rom
  import fprot_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BUS_BYTES = 2
) (
  input  logic [STEP_W-1:0]      step,
  input  logic [ADDR_W-1:0]      base,
  input  logic                   unlock,
  output xfer_kind_e             kind,
  output logic [ADDR_W-1:0]      addr,
  output logic [8*BUS_BYTES-1:0] wdata
);
  localparam int unsigned DATA_W   = 8 * BUS_BYTES;
  localparam int unsigned LOCK_BIT = 6 + $clog2(BUS_BYTES);

  // base plus a word offset scaled to bytes, wrapping in ADDR_W bits
  function automatic logic [ADDR_W-1:0] word_at(input logic [ADDR_W-1:0] b,
                                                input logic [11:0] wofs);
    return b + ADDR_W'(wofs) * ADDR_W'(BUS_BYTES);
  endfunction

  // protection address: base with the selector line forced
  function automatic logic [ADDR_W-1:0] prot_addr(input logic [ADDR_W-1:0] b,
                                                  input logic u);
    logic [ADDR_W-1:0] a;
    a = b;
    a[LOCK_BIT] = u;
    return a;
  endfunction

  function automatic logic [DATA_W-1:0] cmd(input logic [7:0] c);
    return DATA_W'(c);
  endfunction

  always_comb begin
    kind  = XF_NONE;
    addr  = '0;
    wdata = '0;
    unique case (step)
      4'd0, 4'd4, 4'd9: begin kind = XF_WRITE; wdata = cmd(CMD_RESET); end
      4'd1, 4'd2, 4'd3: begin
        kind = XF_WRITE; addr = prot_addr(base, unlock); wdata = cmd(CMD_PROT);
      end
      4'd5: begin kind = XF_WRITE; addr = word_at(base, WOFS_KEY1); wdata = cmd(CMD_KEY1); end
      4'd6: begin kind = XF_WRITE; addr = word_at(base, WOFS_KEY2); wdata = cmd(CMD_KEY2); end
      4'd7: begin kind = XF_WRITE; addr = word_at(base, WOFS_KEY1); wdata = cmd(CMD_IDENT); end
      4'd8: begin kind = XF_READ;  addr = word_at(base, WOFS_STATUS); end
      default: kind = XF_NONE;
    endcase
  end
endmodule

// File: rtl/fprot_judge.sv
module fprot_judge #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] status,
  input  logic              unlock,
  output logic              fail
);
  logic reads_locked;
  assign reads_locked = (status != '0);
  // unlock must read unlocked, lock must read locked
  assign fail = unlock ? reads_locked : !reads_locked;
endmodule

// File: rtl/fprot_seq.sv
module fprot_seq
  import fprot_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BUS_BYTES = 2,
  localparam int unsigned DATA_W   = 8 * BUS_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] sect_base,
  input  logic              unlock,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              fl_we,
  output logic              fl_re,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic [DATA_W-1:0] fl_rdata
);
  logic              busy_q, done_q, err_q, unl_q;
  logic [STEP_W-1:0] step_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] status_q;

  xfer_kind_e        kind;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_wdata;
  logic              verdict_fail;

  // named events for the checker
  logic accept_start, at_last, rd_capture;
  assign accept_start = start && !busy_q;
  assign at_last      = busy_q && (step_q == STEP_W'(LAST_STEP));
  assign rd_capture   = busy_q && (step_q == STEP_W'(RD_STEP));

  fprot_step_rom #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_rom (
    .step(step_q), .base(base_q), .unlock(unl_q),
    .kind(kind), .addr(rom_addr), .wdata(rom_wdata)
  );

  fprot_judge #(.DATA_W(DATA_W)) u_judge (
    .status(status_q), .unlock(unl_q), .fail(verdict_fail)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      unl_q    <= 1'b0;
      step_q   <= '0;
      base_q   <= '0;
      status_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept_start) begin
        busy_q <= 1'b1;
        step_q <= '0;
        base_q <= sect_base;
        unl_q  <= unlock;
      end else if (busy_q) begin
        if (rd_capture) status_q <= fl_rdata;
        if (at_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          err_q  <= verdict_fail;
          step_q <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
  assign fl_we    = busy_q && (kind == XF_WRITE);
  assign fl_re    = busy_q && (kind == XF_READ);
  assign fl_addr  = busy_q ? rom_addr : '0;
  assign fl_wdata = busy_q ? rom_wdata : '0;
endmodule

// File: rtl/fprot_seq_chk.sv
module fprot_seq_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BUS_BYTES = 2,
  localparam int unsigned DATA_W   = 8 * BUS_BYTES,
  localparam int unsigned LOCK_BIT = 6 + $clog2(BUS_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              fl_we,
  input logic              fl_re,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [DATA_W-1:0] fl_wdata,
  input logic              accept_start,
  input logic              at_last,
  input logic              rd_capture,
  input logic              unl_q
);
  a_r1_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept_start |=> busy);
  a_r3_prot_line: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && fl_wdata == DATA_W'(8'h60)) |-> (fl_addr[LOCK_BIT] == unl_q));
  a_r5_read_at_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (fl_re && !fl_we));
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> (done && !busy));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_we, fl_re}));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fl_we && !fl_re));
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !err);
endmodule

bind fprot_seq fprot_seq_chk #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
  .accept_start(accept_start), .at_last(at_last), .rd_capture(rd_capture),
  .unl_q(unl_q)
);

// File: tb/fprot_seq_test.sv
module fprot_seq_test;
  localparam int AW = 16;
  localparam int BB = 2;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, unlock = 1'b0;
  logic [AW-1:0] sect_base = '0;
  logic busy, done, err, fl_we, fl_re;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata, fl_rdata;

  always #4 clk = ~clk;

  fprot_seq #(.ADDR_W(AW), .BUS_BYTES(BB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sect_base(sect_base),
    .unlock(unlock), .busy(busy), .done(done), .err(err),
    .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
  );

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model: per-4KB-sector lock bits, optional stuck protection
  logic [15:0] locked = '0;
  logic        stuck = 1'b0;
  logic        pre_en = 1'b0, pre_val = 1'b0;
  logic [3:0]  pre_sec = '0;
  int          prot_cnt = 0;
  assign fl_rdata = {15'b0, locked[fl_addr[15:12]]};
  always @(posedge clk) begin
    if (pre_en) locked[pre_sec] <= pre_val;
    if (fl_we) begin
      if (fl_wdata == 16'h60) begin
        prot_cnt <= prot_cnt + 1;
        if (prot_cnt == 2 && !stuck) locked[fl_addr[15:12]] <= !fl_addr[7];
      end else prot_cnt <= 0;
    end
  end

  // monitor, sampling on the falling edge
  logic [AW-1:0] log_a [16];
  logic [DW-1:0] log_d [16];
  logic          log_w [16];
  int n_log = 0, n_busy = 0, n_done = 0, cyc = 0;
  logic prev_busy = 1'b0, done_err = 1'b0, done_ok_pos = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (fl_we && fl_re) check(0, "R8 both strobes", 1, 0);
      if ((fl_we || fl_re) && !busy) check(0, "R8 strobe while idle", 1, 0);
      if (err && !done) check(0, "R8 err without done", 1, 0);
      if ((fl_we || fl_re) && n_log < 16) begin
        log_a[n_log] = fl_addr; log_d[n_log] = fl_wdata; log_w[n_log] = fl_we;
        n_log++;
      end
      if (busy) n_busy++;
      if (done) begin
        n_done++; done_err = err; done_ok_pos = prev_busy && !busy;
      end
      prev_busy = busy;
    end
    if (cyc > 20000) begin
      check(0, "watchdog", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run_op(input logic [AW-1:0] b, input bit u, input bit stk,
                        input bit prior, input bit restart);
    logic [AW-1:0] ea [10];
    logic [DW-1:0] ed [10];
    bit            ew [10];
    logic [AW-1:0] sla;
    bit after, exp_err;
    int waited;
    sla = u ? (b | 16'(16'h40 * BB)) : (b & ~16'(16'h40 * BB));
    ea[0] = 0;          ed[0] = 16'hF0; ew[0] = 1;
    for (int i = 1; i <= 3; i++) begin ea[i] = sla; ed[i] = 16'h60; ew[i] = 1; end
    ea[4] = 0;          ed[4] = 16'hF0; ew[4] = 1;
    ea[5] = b + 16'(16'h555 * BB); ed[5] = 16'hAA; ew[5] = 1;
    ea[6] = b + 16'(16'h2AA * BB); ed[6] = 16'h55; ew[6] = 1;
    ea[7] = b + 16'(16'h555 * BB); ed[7] = 16'h90; ew[7] = 1;
    ea[8] = b + 16'(2 * BB);       ed[8] = 16'h00; ew[8] = 0;
    ea[9] = 0;          ed[9] = 16'hF0; ew[9] = 1;
    after   = stk ? prior : !u;
    exp_err = u ? after : !after;
    // preset the sector state in the model
    @(negedge clk); stuck = stk; pre_en = 1; pre_sec = b[15:12]; pre_val = prior;
    @(negedge clk); pre_en = 0;
    n_log = 0; n_busy = 0; n_done = 0; done_ok_pos = 0;
    sect_base = b; unlock = u; start = 1;
    @(negedge clk); start = 0;
    if (restart) begin
      @(negedge clk); @(negedge clk);
      sect_base = b ^ 16'h2000; unlock = !u; start = 1;
      @(negedge clk); start = 0;
    end
    waited = 0;
    while (n_done == 0 && waited < 100) begin @(negedge clk); waited++; end
    check(n_done == 1, "R7 done seen (watchdog)", n_done, 1);
    repeat (3) @(negedge clk);
    check(n_busy == 10, "R1 busy length", n_busy, 10);
    check(n_log == 10, "R1 transfer count", n_log, 10);
    check(n_done == 1, "R7 single done", n_done, 1);
    check(done_ok_pos, "R7 done after busy falls", done_ok_pos, 1);
    check(done_err == exp_err, "R7 err verdict", done_err, exp_err);
    for (int i = 0; i < 10 && i < n_log; i++) begin
      string rq;
      rq = (i == 0) ? "R2" : (i <= 3) ? "R3" : (i <= 7) ? "R4" : (i == 8) ? "R5" : "R6";
      check(log_a[i] == ea[i], {rq, " addr"}, log_a[i], ea[i]);
      check(log_w[i] == ew[i], {rq, " kind"}, log_w[i], ew[i]);
      if (ew[i]) check(log_d[i] == ed[i], {rq, " data"}, log_d[i], ed[i]);
    end
  endtask

  initial begin
    logic [AW-1:0] bases [4];
    bases[0] = 16'h0000; bases[1] = 16'h10C0; bases[2] = 16'h7A00; bases[3] = 16'hF000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !err, "R1 reset idle", {busy, done, err}, 0);
    check(!fl_we && !fl_re, "R8 reset strobes", {fl_we, fl_re}, 0);
    for (int bi = 0; bi < 4; bi++)
      for (int u = 0; u < 2; u++)
        for (int s = 0; s < 2; s++)
          for (int p = 0; p < 2; p++)
            run_op(bases[bi], u[0], s[0], p[0], (bi == 1 && p == 0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule